// File: doc/BRIEF.md
# Branch Target Cache with Last-Outcome Hint

This block keeps a small direct-mapped table beside instruction fetch. Each slot belongs to one branch fetch address. It holds that branch's target and a single bit that says whether the branch was taken when it last executed. Fetch presents its address on the lookup port. One cycle later the block reports whether the address hit, the stored target, and a not-taken hint. The hint is raised only when the slot hit and its stored bit says not-taken.

Branch resolution writes a slot through the update port. Each write stores the tag, the target and the real outcome, so the direction bit always reflects the most recent execution. A flush input empties the whole table in one cycle.

The hint travels with the instruction down to the first decode stage. That stage feeds the block's redirect decision back in. A backward direct conditional branch normally sends fetch to its target, following the static backward-taken rule. A not-taken hint cancels that redirect. A forward branch is never redirected, whatever hint it carries.

Top module: `btc_predictor`

## Requirements
- R1: While reset is held and in the first cycle after it, `lk_hit` and `lk_pred_nt` are 0. Every slot starts invalid, so a lookup of any address misses.
- R2: The table has 64 slots, selected by lookup address bits [7:2]. Address bits [31:8] are stored as the tag. After an update of address X, a lookup of X reports its result in the following cycle with these values:
  - `lk_hit` = 1;
  - `lk_target` = the update target with bits [1:0] forced to 0;
  - `lk_pred_nt` = 1 exactly when the update said not-taken (`up_taken` = 0).
- R3: A lookup whose index matches a valid slot but whose tag differs returns `lk_hit` = 0 and `lk_pred_nt` = 0. An update to that index replaces the previous owner of the slot, and later lookups of the old address miss.
- R4: A later update of the same address overwrites both the direction bit and the target. The next lookup reports the new values.
- R5: When a lookup and an update address the same slot in the same cycle, the update is stored. The lookup reports the slot's contents from before that update.
- R6: A flush clears every valid bit at the clock edge where it is high. An update presented in the same cycle is dropped. A lookup in the flush cycle still sees the old contents. Lookups in later cycles miss.
- R7: `dec_redirect` is 1 when all of the following hold:
  - `dec_valid` = 1;
  - `dec_cond_direct` = 1;
  - `dec_backward` = 1;
  - `dec_pred_nt` = 0.
- R8: A backward direct conditional branch that carries `dec_pred_nt` = 1 gives `dec_redirect` = 0.
- R9: A forward branch (`dec_backward` = 0) gives `dec_redirect` = 0, whatever `dec_pred_nt` is.
- R10: `dec_redirect` = 0 whenever `dec_valid` = 0 or `dec_cond_direct` = 0.
- R11: A cycle with `lk_valid` = 0 yields `lk_hit` = 0 and `lk_pred_nt` = 0 in the following cycle, even if `lk_addr` names a valid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every slot at this edge |
| lk_valid | input | 1 | Fetch lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Previous cycle's lookup hit |
| lk_target | output | 32 | Stored target of the hit slot |
| lk_pred_nt | output | 1 | Hit with last outcome not-taken |
| up_valid | input | 1 | Resolution write request |
| up_addr | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Resolved branch target |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_cond_direct | input | 1 | Instruction is a direct conditional branch |
| dec_backward | input | 1 | Branch displacement is negative |
| dec_pred_nt | input | 1 | Not-taken hint carried from fetch |
| dec_redirect | output | 1 | Decode sends fetch to the branch target |

## Verification
The lookup read and the resolution write can hit the same slot at one clock edge. The flush and a resolution write can also coincide.

The bench provokes both collisions by driving the two requests together on the same address or index. It judges the lookup result against the slot's contents from before the write, per R5. It then issues follow-up lookups to confirm three things:
- the write took effect in the plain collision;
- the write was dropped under flush, per R6;
- a colliding write with a different tag evicted the earlier owner of the slot.

// File: rtl/btc_pkg.sv
package btc_pkg;
    parameter int BTC_ADDR_W  = 32;
    parameter int BTC_INDEX_W = 6;
    parameter int BTC_ALIGN_W = 2;

    typedef struct packed {
        logic valid;
        logic cond_direct;
        logic backward;
        logic pred_nt;
    } dec_info_t;
endpackage

// File: rtl/btc_array.sv
module btc_array
    import btc_pkg::*;
#(
    parameter int ADDR_W  = BTC_ADDR_W,
    parameter int INDEX_W = BTC_INDEX_W,
    parameter int ALIGN_W = BTC_ALIGN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_target,
    input  logic              wr_taken,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    output logic              rd_nt
);
    localparam int ENTRIES = 1 << INDEX_W;
    localparam int TAG_W   = ADDR_W - INDEX_W - ALIGN_W;
    localparam int TGT_W   = ADDR_W - ALIGN_W;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];
    logic [ENTRIES-1:0] tkn_q;

    logic [INDEX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0]   rd_tag, wr_tag;
    logic               wr_go;
    logic               match;

    assign rd_idx = rd_addr[ALIGN_W +: INDEX_W];
    assign wr_idx = wr_addr[ALIGN_W +: INDEX_W];
    assign rd_tag = rd_addr[ADDR_W-1 -: TAG_W];
    assign wr_tag = wr_addr[ADDR_W-1 -: TAG_W];
    assign wr_go  = wr_en && !flush;
    assign match  = rd_en && vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_q[e] <= 1'b0;
            else if (flush)
                vld_q[e] <= 1'b0;
            else if (wr_go && (wr_idx == INDEX_W'(e)))
                vld_q[e] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (wr_go && (wr_idx == INDEX_W'(e))) begin
                tag_q[e] <= wr_tag;
                tgt_q[e] <= wr_target[ADDR_W-1:ALIGN_W];
                tkn_q[e] <= wr_taken;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hit    <= 1'b0;
            rd_nt     <= 1'b0;
            rd_target <= '0;
        end else begin
            rd_hit    <= match;
            rd_nt     <= match && !tkn_q[rd_idx];
            rd_target <= match ? {tgt_q[rd_idx], {ALIGN_W{1'b0}}} : '0;
        end
    end
endmodule

// File: rtl/btc_redirect.sv
module btc_redirect
    import btc_pkg::*;
(
    input  dec_info_t info,
    output logic      redirect
);
    always_comb begin
        redirect = 1'b0;
        if (info.valid && info.cond_direct) begin
            unique case ({info.backward, info.pred_nt})
                2'b10:   redirect = 1'b1;
                default: redirect = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/btc_predictor.sv
module btc_predictor
    import btc_pkg::*;
#(
    parameter int ADDR_W  = BTC_ADDR_W,
    parameter int INDEX_W = BTC_INDEX_W,
    parameter int ALIGN_W = BTC_ALIGN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_target,
    output logic              lk_pred_nt,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [ADDR_W-1:0] up_target,
    input  logic              up_taken,
    input  logic              dec_valid,
    input  logic              dec_cond_direct,
    input  logic              dec_backward,
    input  logic              dec_pred_nt,
    output logic              dec_redirect
);
    dec_info_t dinfo;

    assign dinfo = '{valid: dec_valid, cond_direct: dec_cond_direct,
                     backward: dec_backward, pred_nt: dec_pred_nt};

    btc_array #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .ALIGN_W(ALIGN_W)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .rd_en     (lk_valid),
        .rd_addr   (lk_addr),
        .wr_en     (up_valid),
        .wr_addr   (up_addr),
        .wr_target (up_target),
        .wr_taken  (up_taken),
        .rd_hit    (lk_hit),
        .rd_target (lk_target),
        .rd_nt     (lk_pred_nt)
    );

    btc_redirect i_redirect (
        .info     (dinfo),
        .redirect (dec_redirect)
    );
endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] lk_target,
    input logic              lk_pred_nt,
    input logic              up_valid,
    input logic [ADDR_W-1:0] up_addr,
    input logic [ADDR_W-1:0] up_target,
    input logic              up_taken,
    input logic              dec_valid,
    input logic              dec_cond_direct,
    input logic              dec_backward,
    input logic              dec_pred_nt,
    input logic              dec_redirect
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!lk_hit && !lk_pred_nt));

    p_hint_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pred_nt |-> lk_hit);

    p_update_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_valid && !flush) && lk_valid &&
         (lk_addr[ADDR_W-1:ALIGN_W] == $past(up_addr[ADDR_W-1:ALIGN_W])))
        |=> (lk_hit && (lk_pred_nt == !$past(up_taken, 2)) &&
             (lk_target[ADDR_W-1:ALIGN_W] == $past(up_target[ADDR_W-1:ALIGN_W], 2))));

    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && lk_valid) |=> !lk_hit);

    p_backward_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_cond_direct && dec_backward && !dec_pred_nt) |-> dec_redirect);

    p_nt_suppresses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pred_nt |-> !dec_redirect);

    p_forward_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_backward |-> !dec_redirect);

    p_idle_no_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && !lk_pred_nt));
endmodule

bind btc_predictor btc_checker #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) i_chk (.*);

// File: tb/test_btc_predictor.sv
`timescale 1ns/1ps
module test_btc_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        lk_pred_nt;
    logic        up_valid = 1'b0;
    logic [31:0] up_addr = '0;
    logic [31:0] up_target = '0;
    logic        up_taken = 1'b0;
    logic        dec_valid = 1'b0;
    logic        dec_cond_direct = 1'b0;
    logic        dec_backward = 1'b0;
    logic        dec_pred_nt = 1'b0;
    logic        dec_redirect;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          hit;
        logic [31:0] target;
        bit          nt;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    btc_predictor i_btc_predictor (.*);

    localparam logic [31:0] A  = 32'h0000_1040;
    localparam logic [31:0] B  = 32'h0000_2040;
    localparam logic [31:0] C  = 32'h0000_10C8;
    localparam logic [31:0] D  = 32'h0000_3004;
    localparam logic [31:0] T1 = 32'h0000_0800;
    localparam logic [31:0] T2 = 32'h0000_0F03;
    localparam logic [31:0] T2M = 32'h0000_0F00;
    localparam logic [31:0] TC = 32'h0000_1000;

    task automatic cyc(bit lv, logic [31:0] la, bit uv, logic [31:0] ua,
                       logic [31:0] ut, bit utk, bit fl,
                       bit eh, logic [31:0] et, bit ent, string req);
        exp_t e;
        @(negedge clk);
        lk_valid  = lv;  lk_addr   = la;
        up_valid  = uv;  up_addr   = ua;
        up_target = ut;  up_taken  = utk;
        flush     = fl;
        e.hit = eh; e.target = et; e.nt = ent; e.req = req;
        sb.push_back(e);
    endtask

    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (lk_hit !== e.hit || lk_pred_nt !== e.nt ||
                (e.hit && lk_target !== e.target)) begin
                fails++;
                $display("FAIL %s: hit/nt/target got %b/%b/%h expected %b/%b/%h",
                         e.req, lk_hit, lk_pred_nt, lk_target, e.hit, e.nt, e.target);
            end
        end
    end

    task automatic dec_check(bit v, bit cd, bit bk, bit nt);
        bit exp;
        @(negedge clk);
        dec_valid = v; dec_cond_direct = cd; dec_backward = bk; dec_pred_nt = nt;
        #1;
        exp = v && cd && bk && !nt;
        checks++;
        if (dec_redirect !== exp) begin
            fails++;
            $display("FAIL %s: redirect got %b expected %b (v=%b cd=%b bk=%b nt=%b)",
                     !(v && cd) ? "R10" : (!bk ? "R9" : (nt ? "R8" : "R7")),
                     dec_redirect, exp, v, cd, bk, nt);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (lk_hit !== 1'b0 || lk_pred_nt !== 1'b0) begin
            fails++;
            $display("FAIL R1: in reset hit/nt got %b/%b expected 0/0", lk_hit, lk_pred_nt);
        end
        rst_n = 1'b1;
        cyc(1, A, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        cyc(0, A, 1, A, T1, 1, 0, 0, 0, 0, "R11");
        cyc(1, A, 0, 0, 0, 0, 0, 1, T1, 0, "R2");
        cyc(1, B, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 1, C, TC, 0, 0, 0, 0, 0, "R11");
        cyc(1, C, 0, 0, 0, 0, 0, 1, TC, 1, "R2");
        cyc(0, C, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        cyc(0, 0, 1, A, T1, 0, 0, 0, 0, 0, "R11");
        cyc(1, A, 0, 0, 0, 0, 0, 1, T1, 1, "R4");
        cyc(1, A, 1, A, T2, 1, 0, 1, T1, 1, "R5");
        cyc(1, A, 0, 0, 0, 0, 0, 1, T2M, 0, "R5");
        cyc(1, A, 1, B, TC, 1, 0, 1, T2M, 0, "R5");
        cyc(1, A, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        cyc(1, B, 0, 0, 0, 0, 0, 1, TC, 0, "R3");
        cyc(1, C, 1, D, T1, 1, 1, 1, TC, 1, "R6");
        cyc(1, C, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(1, D, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(1, B, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        @(negedge clk);
        for (int k = 0; k < 16; k++)
            dec_check(k[3], k[2], k[1], k[0]);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule